// File: doc/BRIEF.md
# Dual-Clock Mailbox Pair

Two one-word message registers, 36 bits wide by default, let two ports on unrelated clocks hand single words to each other without going through the queues. The first port (side A) deposits words in the forward mailbox, which side B collects. Side B deposits words in the return mailbox, which side A collects. On each access a per-port select line sends the access either to a mailbox or to the queue path. The queue storage sits outside this block. The block decodes the enable for the queue path, forwards the write data to it, and takes the queue's presented output word into the port's read register.

Each mailbox has an active-low occupied flag. The flag is kept in the depositing port's clock domain. It drops on the edge that deposits a word, and it stays low until the collecting port has taken the word and that acknowledge has crossed back. While the flag is low, further deposits are refused, so the stored word stays stable for the other clock domain. Deposit and collect events cross as toggles through two-stage synchronisers. Each mailbox, together with the read register of the port that collects from it, is cleared by its own active-low reset.

Top module: `mailbox_pair`

## Requirements
- R1: A side-A write with the select high loads the forward mailbox and leaves the queue write strobe low. With the select low, it raises `fwd_q_we` for that cycle with `fwd_q_wdata` equal to `a_din`, and the forward flag does not change.
- R2: A side-A read with the select high loads `a_dout` on that edge with the return mailbox word. With the select low, it raises `ret_q_re` for that cycle and loads `a_dout` with `ret_q_data`. `a_dout` changes only on a side-A read.
- R3: Side B mirrors R1 and R2. Its mailbox write loads the return mailbox, its mailbox read loads `b_dout` with the forward mailbox word, and its queue accesses use `ret_q_we`/`ret_q_wdata` and `fwd_q_re`/`fwd_q_data`.
- R4: A mailbox flag goes low on the depositing clock edge that stores a word. While it is low, further deposits are refused, and the next collect returns the first word.
- R5: After the collecting port's mailbox read, the flag returns high within four cycles of the depositing clock.
- R6: `rst_fwd_n` low forces `fwd_full_n` high and `b_dout` to zero. `rst_ret_n` low forces `ret_full_n` high and `a_dout` to zero. Neither reset affects the other mailbox's flag.
- R7: Side A writes when `a_dir` is 1 and reads when it is 0. Side B writes when `b_dir` is 0 and reads when it is 1.
- R8: No access of any kind takes place unless both the port's chip select and its enable are high on the clock edge.
- R9: A mailbox read while the flag is high returns the last stored word and leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_fwd_n | input | 1 | Active-low reset of the forward mailbox and of `b_dout` |
| a_cs | input | 1 | Side A chip select |
| a_en | input | 1 | Side A enable |
| a_dir | input | 1 | Side A direction, 1 for write and 0 for read |
| a_mbx | input | 1 | Side A target, 1 for mailbox and 0 for queue |
| a_din | input | 36 | Side A write data |
| a_dout | output | 36 | Side A read register |
| fwd_full_n | output | 1 | Forward mailbox flag, low while occupied (clk_a domain) |
| fwd_q_we | output | 1 | Forward queue write strobe |
| fwd_q_wdata | output | 36 | Forward queue write data |
| ret_q_re | output | 1 | Return queue read strobe |
| ret_q_data | input | 36 | Word presented by the return queue |
| clk_b | input | 1 | Side B clock |
| rst_ret_n | input | 1 | Active-low reset of the return mailbox and of `a_dout` |
| b_cs | input | 1 | Side B chip select |
| b_en | input | 1 | Side B enable |
| b_dir | input | 1 | Side B direction, 0 for write and 1 for read |
| b_mbx | input | 1 | Side B target, 1 for mailbox and 0 for queue |
| b_din | input | 36 | Side B write data |
| b_dout | output | 36 | Side B read register |
| ret_full_n | output | 1 | Return mailbox flag, low while occupied (clk_b domain) |
| ret_q_we | output | 1 | Return queue write strobe |
| ret_q_wdata | output | 36 | Return queue write data |
| fwd_q_re | output | 1 | Forward queue read strobe |
| fwd_q_data | input | 36 | Word presented by the forward queue |

## Verification
The visible damage from a lost or doubled toggle is a flag that stays low for good, or one that rises without a collect. Either shows on the next deposit: it is refused, or it overwrites a word that was never read. The check therefore follows each round trip with a second deposit and collect. A wrong access decode shows on the very edge of the access, as a queue strobe firing on a mailbox access or a read register that moves on a write. Reset leakage shows as the untouched mailbox's flag rising the moment the other reset is pulsed.

// File: rtl/mailbox_pair_pkg.sv
package mailbox_pair_pkg;
  parameter int unsigned WORD_W = 36;
  localparam int unsigned SYNC_STAGES = 2;

  // Access decode: chip select and enable both high, direction equal to the
  // port's write level for a write, different from it for a read.
  function automatic logic port_hit(input logic cs, input logic en,
                                    input logic dir, input logic wr_level,
                                    input logic want_wr);
    return cs & en & ((dir == wr_level) == want_wr);
  endfunction

  // Occupied flag (active low): no deposit outstanding when both toggles agree.
  function automatic logic flag_from_toggles(input logic put_tgl, input logic ack_seen);
    return put_tgl == ack_seen;
  endfunction
endpackage

// File: rtl/mbx_sync2.sv
module mbx_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [mailbox_pair_pkg::SYNC_STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[mailbox_pair_pkg::SYNC_STAGES-2:0], d};
  end

  assign q = stage_q[mailbox_pair_pkg::SYNC_STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned W = mailbox_pair_pkg::WORD_W
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         put_req,
  input  logic [W-1:0] put_data,
  input  logic         take_req,
  output logic [W-1:0] word_q,
  output logic         full_n
);
  import mailbox_pair_pkg::*;

  logic put_tgl, ack_tgl, ack_seen, put_seen;
  logic put_ok, take_ok, pending;

  // depositing domain
  assign full_n = flag_from_toggles(put_tgl, ack_seen);
  assign put_ok = put_req & full_n;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      put_tgl <= 1'b0;
      word_q  <= '0;
    end else if (put_ok) begin
      put_tgl <= ~put_tgl;
      word_q  <= put_data;
    end
  end

  mbx_sync2 u_ack_sync (.clk(wclk), .rst_n(rst_n), .d(ack_tgl), .q(ack_seen));

  // collecting domain
  mbx_sync2 u_put_sync (.clk(rclk), .rst_n(rst_n), .d(put_tgl), .q(put_seen));

  assign pending = put_seen ^ ack_tgl;
  assign take_ok = take_req & pending;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)       ack_tgl <= 1'b0;
    else if (take_ok) ack_tgl <= ~ack_tgl;
  end

  // R4: a refused deposit leaves the stored word alone
  assert_put_blocked_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    (put_req && !full_n) |=> $stable(word_q));
  // R4: an accepted deposit drops the flag on that edge
  assert_flag_drops_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    (put_req && full_n) |=> !full_n);
  // R9: a collect with nothing pending sends no acknowledge
  assert_no_spurious_ack_R9: assert property (@(posedge rclk) disable iff (!rst_n)
    (take_req && !pending) |=> $stable(ack_tgl));
  // R6: reset leaves the flag high
  always @(posedge wclk) if (!rst_n) assert_reset_flag_R6: assert (full_n);
endmodule

// File: rtl/mbx_port_ctrl.sv
module mbx_port_ctrl #(
  parameter int unsigned W        = mailbox_pair_pkg::WORD_W,
  parameter bit          WR_LEVEL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         en,
  input  logic         dir,
  input  logic         mbx,
  input  logic [W-1:0] din,
  input  logic [W-1:0] mail_in,
  input  logic [W-1:0] q_in,
  output logic         mbx_wr,
  output logic         mbx_rd,
  output logic         q_we,
  output logic [W-1:0] q_wdata,
  output logic         q_re,
  output logic [W-1:0] dout
);
  import mailbox_pair_pkg::*;

  logic wr_hit, rd_hit;

  assign wr_hit  = port_hit(cs, en, dir, WR_LEVEL, 1'b1);
  assign rd_hit  = port_hit(cs, en, dir, WR_LEVEL, 1'b0);
  assign mbx_wr  = wr_hit & mbx;
  assign q_we    = wr_hit & ~mbx;
  assign mbx_rd  = rd_hit & mbx;
  assign q_re    = rd_hit & ~mbx;
  assign q_wdata = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout <= '0;
    else if (rd_hit) dout <= mbx ? mail_in : q_in;
  end

  // R7: one kind of access per edge at most
  assert_one_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mbx_wr, mbx_rd, q_we, q_re}));
  // R8: no strobe without chip select and enable
  assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && en) |-> !(mbx_wr || mbx_rd || q_we || q_re));
  // R2: the read register moves only on a read
  assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mbx_rd || q_re) |=> $stable(dout));
endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair #(
  parameter int unsigned W = mailbox_pair_pkg::WORD_W
) (
  input  logic         clk_a,
  input  logic         rst_fwd_n,
  input  logic         a_cs,
  input  logic         a_en,
  input  logic         a_dir,
  input  logic         a_mbx,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         fwd_full_n,
  output logic         fwd_q_we,
  output logic [W-1:0] fwd_q_wdata,
  output logic         ret_q_re,
  input  logic [W-1:0] ret_q_data,
  input  logic         clk_b,
  input  logic         rst_ret_n,
  input  logic         b_cs,
  input  logic         b_en,
  input  logic         b_dir,
  input  logic         b_mbx,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] b_dout,
  output logic         ret_full_n,
  output logic         ret_q_we,
  output logic [W-1:0] ret_q_wdata,
  output logic         fwd_q_re,
  input  logic [W-1:0] fwd_q_data
);
  logic         a_put, a_take, b_put, b_take;
  logic [W-1:0] fwd_word, ret_word;

  mbx_port_ctrl #(.W(W), .WR_LEVEL(1'b1)) u_port_a (
    .clk(clk_a), .rst_n(rst_ret_n), .cs(a_cs), .en(a_en), .dir(a_dir), .mbx(a_mbx),
    .din(a_din), .mail_in(ret_word), .q_in(ret_q_data),
    .mbx_wr(a_put), .mbx_rd(a_take), .q_we(fwd_q_we), .q_wdata(fwd_q_wdata),
    .q_re(ret_q_re), .dout(a_dout));

  mbx_port_ctrl #(.W(W), .WR_LEVEL(1'b0)) u_port_b (
    .clk(clk_b), .rst_n(rst_fwd_n), .cs(b_cs), .en(b_en), .dir(b_dir), .mbx(b_mbx),
    .din(b_din), .mail_in(fwd_word), .q_in(fwd_q_data),
    .mbx_wr(b_put), .mbx_rd(b_take), .q_we(ret_q_we), .q_wdata(ret_q_wdata),
    .q_re(fwd_q_re), .dout(b_dout));

  mbx_channel #(.W(W)) u_fwd (
    .wclk(clk_a), .rclk(clk_b), .rst_n(rst_fwd_n),
    .put_req(a_put), .put_data(a_din), .take_req(b_take),
    .word_q(fwd_word), .full_n(fwd_full_n));

  mbx_channel #(.W(W)) u_ret (
    .wclk(clk_b), .rclk(clk_a), .rst_n(rst_ret_n),
    .put_req(b_put), .put_data(b_din), .take_req(a_take),
    .word_q(ret_word), .full_n(ret_full_n));

  // R1: a side-A mailbox write never strobes the forward queue
  assert_no_queue_on_mbx_R1: assert property (@(posedge clk_a) disable iff (!rst_fwd_n)
    (a_cs && a_en && a_dir && a_mbx) |-> !fwd_q_we);
  // R3: a side-B mailbox write never strobes the return queue
  assert_no_queue_on_mbx_R3: assert property (@(posedge clk_b) disable iff (!rst_ret_n)
    (b_cs && b_en && !b_dir && b_mbx) |-> !ret_q_we);
endmodule

// File: tb/mailbox_pair_bench.sv
module mailbox_pair_bench;
  localparam int W = 36;

  logic clk_a = 0, clk_b = 0;
  logic rst_fwd_n = 0, rst_ret_n = 0;
  logic a_cs = 0, a_en = 0, a_dir = 0, a_mbx = 0;
  logic b_cs = 0, b_en = 0, b_dir = 0, b_mbx = 0;
  logic [W-1:0] a_din = '0, b_din = '0, ret_q_data = '0, fwd_q_data = '0;
  logic [W-1:0] a_dout, b_dout, fwd_q_wdata, ret_q_wdata;
  logic fwd_full_n, ret_full_n, fwd_q_we, ret_q_re, ret_q_we, fwd_q_re;

  int checks = 0, failures = 0;
  logic cap_we, cap_re;
  logic [W-1:0] cap_wdata;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  mailbox_pair u_mailbox_pair (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic cs, input logic en, input logic dir,
                      input logic mbx, input logic [W-1:0] d);
    @(negedge clk_a);
    a_cs = cs; a_en = en; a_dir = dir; a_mbx = mbx; a_din = d;
    #1;
    cap_we = fwd_q_we; cap_wdata = fwd_q_wdata; cap_re = ret_q_re;
    @(negedge clk_a);
    a_cs = 0; a_en = 0;
  endtask

  task automatic b_op(input logic cs, input logic en, input logic dir,
                      input logic mbx, input logic [W-1:0] d);
    @(negedge clk_b);
    b_cs = cs; b_en = en; b_dir = dir; b_mbx = mbx; b_din = d;
    #1;
    cap_we = ret_q_we; cap_wdata = ret_q_wdata; cap_re = fwd_q_re;
    @(negedge clk_b);
    b_cs = 0; b_en = 0;
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(negedge clk_a);
  endtask

  task automatic wait_b(input int n);
    repeat (n) @(negedge clk_b);
  endtask

  task automatic t_reset_state;
    check("R6 fwd flag", fwd_full_n, 1);
    check("R6 ret flag", ret_full_n, 1);
    check("R6 a_dout", a_dout, 0);
    check("R6 b_dout", b_dout, 0);
  endtask

  task automatic t_forward_round_trip;
    a_op(1, 1, 1, 1, 36'h1_1111_1111);
    check("R1 no queue strobe", cap_we, 0);
    check("R4 flag low", fwd_full_n, 0);
    a_op(1, 1, 1, 1, 36'h2_2222_2222);
    check("R4 still low", fwd_full_n, 0);
    wait_b(3);
    b_op(1, 1, 1, 1, '0);
    check("R3 b collects first word", b_dout, 36'h1_1111_1111);
    check("R4 refused write kept out", b_dout, 36'h1_1111_1111);
    wait_a(4);
    check("R5 flag back high", fwd_full_n, 1);
    b_op(1, 1, 1, 1, '0);
    check("R9 empty read value", b_dout, 36'h1_1111_1111);
    wait_a(3);
    check("R9 flag unchanged", fwd_full_n, 1);
  endtask

  task automatic t_queue_paths;
    a_op(1, 1, 1, 0, 36'h9_8765_4321);
    check("R1 fwd_q_we", cap_we, 1);
    check("R1 fwd_q_wdata", cap_wdata, 36'h9_8765_4321);
    check("R1 flag untouched", fwd_full_n, 1);
    ret_q_data = 36'h3_3333_0000;
    a_op(1, 1, 0, 0, '0);
    check("R2 ret_q_re", cap_re, 1);
    check("R2 a_dout from queue", a_dout, 36'h3_3333_0000);
    fwd_q_data = 36'h4_4444_0000;
    b_op(1, 1, 1, 0, '0);
    check("R3 fwd_q_re", cap_re, 1);
    check("R3 b_dout from queue", b_dout, 36'h4_4444_0000);
    b_op(1, 1, 0, 0, 36'h5_0000_0005);
    check("R3 ret_q_we", cap_we, 1);
    check("R3 ret_q_wdata", cap_wdata, 36'h5_0000_0005);
  endtask

  task automatic t_return_round_trip;
    b_op(1, 1, 0, 1, 36'hA_BCDE_F012);
    check("R3 ret flag low", ret_full_n, 0);
    check("R2 a_dout holds on B write", a_dout, 36'h3_3333_0000);
    wait_a(3);
    a_op(1, 1, 0, 1, '0);
    check("R2 a collects mailbox", a_dout, 36'hA_BCDE_F012);
    wait_b(4);
    check("R5 ret flag high", ret_full_n, 1);
  endtask

  task automatic t_polarity_and_gating;
    a_op(1, 1, 0, 1, 36'h7_7777_7777);
    check("R7 A dir=0 is read, flag", fwd_full_n, 1);
    check("R9 A empty read value", a_dout, 36'hA_BCDE_F012);
    b_op(1, 1, 1, 1, 36'h6_6666_6666);
    check("R7 B dir=1 is read, flag", ret_full_n, 1);
    a_op(0, 1, 1, 1, 36'h8_0000_0008);
    check("R8 cs low flag", fwd_full_n, 1);
    a_op(1, 0, 1, 0, 36'h8_0000_0008);
    check("R8 en low queue strobe", cap_we, 0);
    ret_q_data = 36'hF_0000_000F;
    a_op(0, 1, 0, 0, '0);
    check("R8 cs low no read", a_dout, 36'hA_BCDE_F012);
    check("R8 cs low no read strobe", cap_re, 0);
  endtask

  task automatic t_reset_split;
    a_op(1, 1, 1, 1, 36'h0_0000_0055);
    b_op(1, 1, 0, 1, 36'h0_0000_0066);
    wait_a(4);
    #1 rst_fwd_n = 0;
    wait_b(3);
    check("R6 fwd flag forced high", fwd_full_n, 1);
    check("R6 b_dout cleared", b_dout, 0);
    check("R6 ret flag kept", ret_full_n, 0);
    #1 rst_fwd_n = 1;
    wait_a(2);
    a_op(1, 1, 0, 1, '0);
    check("R2 return word after fwd reset", a_dout, 36'h0_0000_0066);
    wait_b(4);
    check("R5 ret flag high after drain", ret_full_n, 1);
  endtask

  initial begin
    wait_a(4);
    t_reset_state;
    #1 rst_fwd_n = 1; rst_ret_n = 1;
    wait_a(2);
    t_forward_round_trip;
    t_queue_paths;
    t_return_round_trip;
    t_polarity_and_gating;
    t_reset_split;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule